// File: doc/BRIEF.md
# Two-Level Priority Vectored Interrupt Controller

This block collects interrupt events for a small processor, turns them into request flags and picks one vector to present to the CPU. Seven vectored sources are arbitrated: a basic-timer tick and a both-edge pin that share vector 0, two edge-programmable pins (one of them behind a sampled noise filter), a serial-transfer-done pulse, a timer-match pulse, a falling edge on the chip-enable pin and an IF-gate-closed pulse. Two further quasi-interrupt flags are only recorded and never produce a vector. One is set by a rising edge on a test pin or by a falling edge on a group of four key lines. The other is set by a watch-timer tick.

A 3-bit priority setting may lift one source above all others. A 2-bit nesting status limits preemption. At level 0 any enabled request is accepted. At level 1 only the lifted source may enter. At level 2 nothing enters. The CPU accepts the presented vector with a one-cycle acknowledge and leaves a handler with a one-cycle return strobe. Pin inputs are assumed to be already synchronous to the clock.

Top module: `vic_top`

## Requirements
- R1: After reset `irq_flags` is all zero, `nest_st` is 00 and `vec_req` is 0. Flag bits are: 0 basic timer, 1 both-edge pin, 2 filtered pin, 3 edge pin 1, 4 serial done, 5 timer match, 6 chip-enable fall, 7 IF gate, 8 key/test-pin quasi flag, 9 watch-timer quasi flag.
- R2: A source event sets its flag one clock later. A `sw_clr` bit clears the matching flag. An event in the same cycle as a clear leaves the flag set.
- R3: `vec_req` is 1 only when some vectored source has its flag, its `ien` bit (bit k enables flag k, k = 0..7) and `ime` all at 1. A flag whose enables are missing stays set and is presented once they arrive.
- R4: With `nest_st` 00 any eligible source is presented. With 01 only the lifted source is. With 10 none is. `nest_st` never reads 11.
- R5: Vector indexes are 0 (flags 0/1), 1 (flag 2), 2 (flag 3), 3 (flag 4), 4 (flag 5), 5 (flag 6), 6 (flag 7). When `ipr` = k (k = 1..7), index k-1 is the lifted source and wins whenever it is eligible. Otherwise the lowest eligible index wins. `ipr` = 000 lifts nothing.
- R6: `vec_ack` while `vec_req` is 1 clears the flag of the presented vector and raises `nest_st` by one.
- R7: `reti` lowers `nest_st` by one, down to 00. When `reti` and `vec_ack` coincide, the acknowledge is ignored and no flag is cleared.
- R8: When vector 0 is acknowledged with both `ien[0]` and `ien[1]` set, flags 0 and 1 stay set. With only one of them enabled, that one is cleared.
- R9: The both-edge pin sets flag 1 on rising and on falling edges. Edge pin 1 sets flag 3 on its falling edge when `int1_fall` = 1, and on its rising edge when `int1_fall` = 0.
- R10: The filtered pin is sampled every `SMP_DIV` clocks and changes its filtered level only after `FILT_TAPS` equal samples. A pulse of 2·`SMP_DIV` clocks or less is never accepted. The selected edge (rising when `int0_fall` = 0, falling when 1) of the filtered level sets flag 2.
- R11: Flag 8 is set by a rising edge on `int2_pin`, or when all `key_pin` lines were high in one cycle and at least one is low in the next. No key edge is detected while any key line stays low.
- R12: Flags 8 and 9 never cause `vec_req` and are never cleared by an acknowledge, only by `sw_clr`. `wt_evt` sets flag 9.
- R13: A falling edge on `ce_pin` sets flag 6. A rising edge does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bt_evt | input | 1 | Basic-timer interval pulse |
| ser_evt | input | 1 | Serial transfer done pulse |
| tm_evt | input | 1 | Timer match pulse |
| ifg_evt | input | 1 | IF gate closed pulse |
| wt_evt | input | 1 | Watch-timer tick pulse |
| int4_pin | input | 1 | Both-edge interrupt pin |
| int0_pin | input | 1 | Filtered interrupt pin |
| int0_fall | input | 1 | Edge select for the filtered pin, 1 = falling |
| int1_pin | input | 1 | Edge-programmable interrupt pin |
| int1_fall | input | 1 | Edge select for int1_pin, 1 = falling |
| ce_pin | input | 1 | Chip-enable pin, falling edge interrupts |
| int2_pin | input | 1 | Quasi-interrupt test pin, rising edge |
| key_pin | input | 4 | Key lines, falling edge quasi-interrupt |
| ien | input | 8 | Per-flag enables for flags 0..7 |
| ime | input | 1 | Global enable |
| ipr | input | 3 | Priority lift select |
| sw_clr | input | 10 | Software clear, one bit per flag |
| vec_ack | input | 1 | CPU accepts the presented vector |
| reti | input | 1 | CPU returns from a handler |
| irq_flags | output | 10 | Request flags |
| vec_req | output | 1 | A vector is presented |
| vec_idx | output | 3 | Index of the presented vector |
| nest_st | output | 2 | Nesting status |

## Verification
The bench builds the block with `SMP_DIV` = 4 and `FILT_TAPS` = 3. With these values a filter rejection window of 8 clocks and an acceptance within a few tens of clocks can both be probed cheaply. A pulse of 8 clocks is shown to be lost, and a level held for 30 clocks is shown to be taken on either selected edge. The same setting keeps the nesting walk short. That walk goes through every status level with the priority lift both present and absent.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NVEC   = 7;
    localparam int NFLAG  = NVEC + 3;
    localparam int IDX_W  = $clog2(NVEC);
    localparam int NEN    = NVEC + 1;

    localparam int F_BT   = 0;
    localparam int F_K4   = 1;
    localparam int F_QKEY = NEN;
    localparam int F_QWT  = NEN + 1;

    localparam logic [1:0] ST_L0 = 2'd0;
    localparam logic [1:0] ST_L1 = 2'd1;
    localparam logic [1:0] ST_L2 = 2'd2;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
        logic [1:0]       st;
        logic [3:0]       key_prev;
        logic             key_arm;
    } vic_state_t;
endpackage

// File: rtl/vic_edge.sv
module vic_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig,
    input  logic [1:0] mode,
    output logic       hit
);
    logic prev_d, prev_q;
    logic arm_d, arm_q;

    always_comb begin
        prev_d = sig;
        arm_d  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            prev_q <= prev_d;
            arm_q  <= arm_d;
        end
    end

    assign hit = arm_q & ((mode[0] & sig & ~prev_q) | (mode[1] & ~sig & prev_q));
endmodule

// File: rtl/vic_filt.sv
module vic_filt #(
    parameter int SMP_DIV   = 4,
    parameter int FILT_TAPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (SMP_DIV > 2) ? $clog2(SMP_DIV) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(SMP_DIV - 1);

    logic [CW-1:0]        cnt_d, cnt_q;
    logic [FILT_TAPS-1:0] taps_d, taps_q;
    logic                 out_d, out_q;

    always_comb begin
        cnt_d  = (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
        taps_d = taps_q;
        if (cnt_q == CNT_TOP)
            taps_d = {taps_q[FILT_TAPS-2:0], din};
        out_d = out_q;
        if (&taps_q)
            out_d = 1'b1;
        else if (~|taps_q)
            out_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            taps_q <= '0;
            out_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            taps_q <= taps_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/vic_arb.sv
module vic_arb
    import vic_pkg::*;
(
    input  logic [NVEC-1:0]  pend,
    input  logic [2:0]       ipr,
    input  logic [1:0]       st,
    output logic             req,
    output logic [IDX_W-1:0] idx
);
    logic             lift_ok;
    logic [IDX_W-1:0] lift_idx;

    always_comb begin
        lift_idx = IDX_W'(ipr - 3'd1);
        lift_ok  = (ipr != 3'd0) && pend[lift_idx];
        req      = 1'b0;
        idx      = '0;
        if (st == ST_L0) begin
            if (lift_ok) begin
                req = 1'b1;
                idx = lift_idx;
            end else begin
                for (int i = NVEC - 1; i >= 0; i--) begin
                    if (pend[i]) begin
                        req = 1'b1;
                        idx = IDX_W'(i);
                    end
                end
            end
        end else if (st == ST_L1 && lift_ok) begin
            req = 1'b1;
            idx = lift_idx;
        end
    end
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int SMP_DIV   = 4,
    parameter int FILT_TAPS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bt_evt,
    input  logic             ser_evt,
    input  logic             tm_evt,
    input  logic             ifg_evt,
    input  logic             wt_evt,
    input  logic             int4_pin,
    input  logic             int0_pin,
    input  logic             int0_fall,
    input  logic             int1_pin,
    input  logic             int1_fall,
    input  logic             ce_pin,
    input  logic             int2_pin,
    input  logic [3:0]       key_pin,
    input  logic [NEN-1:0]   ien,
    input  logic             ime,
    input  logic [2:0]       ipr,
    input  logic [NFLAG-1:0] sw_clr,
    input  logic             vec_ack,
    input  logic             reti,
    output logic [NFLAG-1:0] irq_flags,
    output logic             vec_req,
    output logic [IDX_W-1:0] vec_idx,
    output logic [1:0]       nest_st
);
    vic_state_t s_d, s_q;

    logic e4, e0, e1, ece, e2, f0_lvl;
    logic [NVEC-1:0] pend;

    vic_edge u_e4 (.clk(clk), .rst_n(rst_n), .sig(int4_pin), .mode(2'b11), .hit(e4));
    vic_filt #(.SMP_DIV(SMP_DIV), .FILT_TAPS(FILT_TAPS))
        u_f0 (.clk(clk), .rst_n(rst_n), .din(int0_pin), .dout(f0_lvl));
    vic_edge u_e0 (.clk(clk), .rst_n(rst_n), .sig(f0_lvl),
                   .mode(int0_fall ? 2'b10 : 2'b01), .hit(e0));
    vic_edge u_e1 (.clk(clk), .rst_n(rst_n), .sig(int1_pin),
                   .mode(int1_fall ? 2'b10 : 2'b01), .hit(e1));
    vic_edge u_ec (.clk(clk), .rst_n(rst_n), .sig(ce_pin), .mode(2'b10), .hit(ece));
    vic_edge u_e2 (.clk(clk), .rst_n(rst_n), .sig(int2_pin), .mode(2'b01), .hit(e2));

    // vectored eligibility: vector 0 is shared by flags 0 and 1
    always_comb begin
        pend[0] = ime & ((s_q.flags[F_BT] & ien[F_BT]) | (s_q.flags[F_K4] & ien[F_K4]));
        for (int v = 1; v < NVEC; v++)
            pend[v] = ime & s_q.flags[v+1] & ien[v+1];
    end

    vic_arb u_arb (.pend(pend), .ipr(ipr), .st(s_q.st), .req(vec_req), .idx(vec_idx));

    logic [NFLAG-1:0] set_v, clr_v;
    logic             take, key_fall;

    always_comb begin
        s_d      = s_q;
        key_fall = s_q.key_arm & (&s_q.key_prev) & ~(&key_pin);
        set_v    = {wt_evt, e2 | key_fall, ifg_evt, ece, tm_evt, ser_evt, e1, e0, e4, bt_evt};
        take     = vec_req & vec_ack & ~reti;
        clr_v    = sw_clr;
        if (take) begin
            if (vec_idx == '0) begin
                if (!(ien[F_BT] && ien[F_K4])) begin
                    clr_v[F_BT] = clr_v[F_BT] | ien[F_BT];
                    clr_v[F_K4] = clr_v[F_K4] | ien[F_K4];
                end
            end else begin
                clr_v[32'(vec_idx) + 1] = 1'b1;
            end
        end
        s_d.flags    = (s_q.flags & ~clr_v) | set_v;
        s_d.key_prev = key_pin;
        s_d.key_arm  = 1'b1;
        if (reti) begin
            if (s_q.st != ST_L0)
                s_d.st = s_q.st - 2'd1;
        end else if (take) begin
            s_d.st = s_q.st + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.flags    <= '0;
            s_q.st       <= ST_L0;
            s_q.key_prev <= 4'hF;
            s_q.key_arm  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_flags = s_q.flags;
    assign nest_st   = s_q.st;
endmodule

// File: rtl/vic_chk.sv
module vic_chk
    import vic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ime,
    input logic [2:0]       ipr,
    input logic             vec_ack,
    input logic             reti,
    input logic [NFLAG-1:0] irq_flags,
    input logic             vec_req,
    input logic [IDX_W-1:0] vec_idx,
    input logic [1:0]       nest_st
);
    a_r4_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        nest_st != 2'b11);

    a_r4_top_level_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_st == ST_L2) |-> !vec_req);

    a_r4_level1_lift_only: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_st == ST_L1 && vec_req) |-> (ipr != 3'd0 && 3'(vec_idx) == ipr - 3'd1));

    a_r3_req_needs_ime: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> ime);

    a_r6_ack_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && vec_ack && !reti) |=> (nest_st == $past(nest_st) + 2'd1));

    a_r7_reti_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && nest_st != ST_L0) |=> (nest_st == $past(nest_st) - 2'd1));

    a_r12_quasi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[F_QWT] && vec_ack) |=> irq_flags[F_QWT]);
endmodule

bind vic_top vic_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ime(ime), .ipr(ipr), .vec_ack(vec_ack), .reti(reti),
    .irq_flags(irq_flags), .vec_req(vec_req), .vec_idx(vec_idx), .nest_st(nest_st)
);

// File: tb/vic_top_tb_top.sv
module vic_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bt_evt = 0, ser_evt = 0, tm_evt = 0, ifg_evt = 0, wt_evt = 0;
    logic       int4_pin = 0, int0_pin = 0, int0_fall = 0, int1_pin = 0, int1_fall = 0;
    logic       ce_pin = 1, int2_pin = 0;
    logic [3:0] key_pin = 4'hF;
    logic [7:0] ien = 8'h00;
    logic       ime = 0;
    logic [2:0] ipr = 3'd0;
    logic [9:0] sw_clr = '0;
    logic       vec_ack = 0, reti = 0;
    logic [9:0] irq_flags;
    logic       vec_req;
    logic [2:0] vec_idx;
    logic [1:0] nest_st;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vic_top #(.SMP_DIV(4), .FILT_TAPS(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .bt_evt(bt_evt), .ser_evt(ser_evt), .tm_evt(tm_evt),
        .ifg_evt(ifg_evt), .wt_evt(wt_evt), .int4_pin(int4_pin), .int0_pin(int0_pin),
        .int0_fall(int0_fall), .int1_pin(int1_pin), .int1_fall(int1_fall), .ce_pin(ce_pin),
        .int2_pin(int2_pin), .key_pin(key_pin), .ien(ien), .ime(ime), .ipr(ipr),
        .sw_clr(sw_clr), .vec_ack(vec_ack), .reti(reti), .irq_flags(irq_flags),
        .vec_req(vec_req), .vec_idx(vec_idx), .nest_st(nest_st));

    typedef struct packed {
        logic [7:0] ien;
        logic       ime;
        logic [2:0] ipr;
        logic [3:0] ev;   // {ifg, tm, ser, bt}
        logic       req;
        logic [2:0] idx;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{8'hFF, 1'b1, 3'd0, 4'b0110, 1'b1, 3'd3},
        '{8'hFF, 1'b1, 3'd7, 4'b1100, 1'b1, 3'd6},
        '{8'hFF, 1'b1, 3'd0, 4'b1001, 1'b1, 3'd0},
        '{8'hEF, 1'b1, 3'd0, 4'b0010, 1'b0, 3'd0},
        '{8'hFF, 1'b0, 3'd0, 4'b0010, 1'b0, 3'd0},
        '{8'hFF, 1'b1, 3'd5, 4'b1111, 1'b1, 3'd4},
        '{8'hFF, 1'b1, 3'd1, 4'b1010, 1'b1, 3'd3},
        '{8'hFF, 1'b1, 3'd0, 4'b1000, 1'b1, 3'd6}
    };

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        sw_clr = '1;
        step();
        sw_clr = '0;
    endtask

    task automatic ack();
        vec_ack = 1;
        step();
        vec_ack = 0;
    endtask

    task automatic ret();
        reti = 1;
        step();
        reti = 0;
    endtask

    initial begin
        step(3);
        // R1 reset state
        chk(irq_flags == 0 && nest_st == 0 && vec_req == 0, "R1 reset", int'(irq_flags), 0);
        rst_n = 1;
        step(3);

        // table walk: R3/R5 arbitration at level 0
        for (int i = 0; i < NV; i++) begin
            clear_all();
            ien = TBL[i].ien; ime = TBL[i].ime; ipr = TBL[i].ipr;
            {ifg_evt, tm_evt, ser_evt, bt_evt} = TBL[i].ev;
            step();
            {ifg_evt, tm_evt, ser_evt, bt_evt} = 4'b0;
            chk(vec_req == TBL[i].req, $sformatf("R3 vector %0d req", i), vec_req, TBL[i].req);
            if (TBL[i].req)
                chk(vec_idx == TBL[i].idx, $sformatf("R5 vector %0d idx", i), vec_idx, TBL[i].idx);
        end

        // R3 retention until global enable
        clear_all();
        ien = 8'hFF; ime = 0; ipr = 0;
        ser_evt = 1; step(); ser_evt = 0; step(2);
        chk(vec_req == 0 && irq_flags[4], "R3 retained", int'(irq_flags), 16);
        ime = 1; #1;
        chk(vec_req && vec_idx == 3, "R3 late enable", vec_idx, 3);

        // R6/R4/R7 nesting walk with timer match lifted (ipr=5 -> index 4)
        clear_all();
        ipr = 3'd5;
        ser_evt = 1; step(); ser_evt = 0;
        ack();
        chk(nest_st == 1 && !irq_flags[4], "R6 accept low", nest_st, 1);
        ifg_evt = 1; step(); ifg_evt = 0;
        chk(vec_req == 0, "R4 level1 blocks low", vec_req, 0);
        tm_evt = 1; step(); tm_evt = 0;
        chk(vec_req && vec_idx == 4, "R4 level1 lifted preempts", vec_idx, 4);
        ack();
        chk(nest_st == 2 && !irq_flags[5], "R6 accept lifted", nest_st, 2);
        bt_evt = 1; step(); bt_evt = 0;
        chk(vec_req == 0, "R4 level2 blocks all", vec_req, 0);
        ret();
        chk(nest_st == 1 && vec_req == 0, "R7 step down to 1", nest_st, 1);
        ret();
        chk(nest_st == 0 && vec_req && vec_idx == 0, "R7 step down to 0", vec_idx, 0);
        vec_ack = 1; reti = 1; step(); vec_ack = 0; reti = 0;
        chk(nest_st == 0 && irq_flags[0], "R7 reti overrides ack", nest_st, 0);
        ret();
        chk(nest_st == 0, "R7 floor at 0", nest_st, 0);

        // R5 no lift: first accepted cannot be preempted
        clear_all();
        ipr = 0;
        ifg_evt = 1; step(); ifg_evt = 0;
        ack();
        bt_evt = 1; step(); bt_evt = 0;
        chk(nest_st == 1 && vec_req == 0, "R5 no lift no preempt", vec_req, 0);
        ret();

        // R8 shared vector
        clear_all();
        ien = 8'hFF;
        bt_evt = 1; step(); bt_evt = 0;
        ack();
        chk(irq_flags[0] == 1 && nest_st == 1, "R8 shared both enabled keeps", irq_flags[0], 1);
        ret();
        ien = 8'hFD;
        ack();
        chk(irq_flags[0] == 0, "R8 single enabled clears", irq_flags[0], 0);
        ret();
        ien = 8'hFF;

        // R2 set wins over clear
        clear_all();
        tm_evt = 1; sw_clr[5] = 1; step(); tm_evt = 0; sw_clr = '0;
        chk(irq_flags[5] == 1, "R2 set beats clear", irq_flags[5], 1);
        sw_clr[5] = 1; step(); sw_clr = '0;
        chk(irq_flags[5] == 0, "R2 software clear", irq_flags[5], 0);

        // R9 both-edge pin and edge select
        clear_all();
        int4_pin = 1; step();
        chk(irq_flags[1] == 1, "R9 both-edge rise", irq_flags[1], 1);
        clear_all();
        int4_pin = 0; step();
        chk(irq_flags[1] == 1, "R9 both-edge fall", irq_flags[1], 1);
        clear_all();
        int1_fall = 1; int1_pin = 1; step();
        chk(irq_flags[3] == 0, "R9 falling mode ignores rise", irq_flags[3], 0);
        int1_pin = 0; step();
        chk(irq_flags[3] == 1, "R9 falling mode", irq_flags[3], 1);

        // R10 noise filter
        clear_all();
        int0_pin = 1; step(8); int0_pin = 0; step(30);
        chk(irq_flags[2] == 0, "R10 short pulse rejected", irq_flags[2], 0);
        int0_pin = 1; step(30);
        chk(irq_flags[2] == 1, "R10 long level rising", irq_flags[2], 1);
        int0_fall = 1; clear_all();
        int0_pin = 0; step(6); int0_pin = 1; step(30);
        chk(irq_flags[2] == 0, "R10 short low rejected", irq_flags[2], 0);
        int0_pin = 0; step(30);
        chk(irq_flags[2] == 1, "R10 long level falling", irq_flags[2], 1);

        // R11 keys and test pin
        clear_all();
        ien = 8'h00;
        key_pin = 4'b1110; step();
        chk(irq_flags[8] == 1, "R11 key fall", irq_flags[8], 1);
        clear_all();
        key_pin = 4'b1100; step(2);
        chk(irq_flags[8] == 0, "R11 key suppressed while low", irq_flags[8], 0);
        key_pin = 4'hF; step(); key_pin = 4'b1011; step();
        chk(irq_flags[8] == 1, "R11 key after release", irq_flags[8], 1);
        clear_all();
        int2_pin = 1; step();
        chk(irq_flags[8] == 1, "R11 test pin rise", irq_flags[8], 1);

        // R12 quasi flags
        clear_all();
        ien = 8'hFF;
        wt_evt = 1; step(); wt_evt = 0;
        int2_pin = 0; step();
        chk(irq_flags[9] == 1 && vec_req == 0, "R12 quasi no vector", vec_req, 0);
        vec_ack = 1; step(); vec_ack = 0;
        chk(irq_flags[9] == 1, "R12 quasi sticky", irq_flags[9], 1);
        sw_clr[9] = 1; step(); sw_clr = '0;
        chk(irq_flags[9] == 0, "R12 quasi software clear", irq_flags[9], 0);

        // R13 chip-enable edge
        clear_all();
        ce_pin = 0; step();
        chk(irq_flags[6] == 1 && vec_req && vec_idx == 5, "R13 ce fall", vec_idx, 5);
        clear_all();
        ce_pin = 1; step();
        chk(irq_flags[6] == 0, "R13 ce rise ignored", irq_flags[6], 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule